// File: doc/BRIEF.md
# Bit-Clock Recovery Loop Mode Controller

This block supervises a digital bit-clock recovery loop. It decides which of three operating modes the loop runs in. The wide-range outer frequency aid has no capture limit and only has to bring the loop close to the nominal rate. The near-lock inner aid covers a window of one tenth of the nominal rate around that point and pulls the loop to lock. Linear tracking is the normal in-lock mode. In automatic operation the controller climbs through these tiers on check strobes from the loop's lock detector. When lock is lost, it falls back one tier.

A host reaches the block over a small byte-wide register port. Through that port it can hold the loop in any mode and preset the loop frequency. It can also read back the mode, the internal lock flags and the top byte of the loop frequency word. A preset is two register writes. The preset path then drives a one-cycle load strobe into the loop integrator, followed by a one-cycle hold. While the strobe or the hold is high, lock-detector checks are discarded, because they describe a frequency that no longer exists.

The lock-detector strobe and the host port are plain control pins with no back-pressure. A check is taken on any cycle in which `chk_valid` is high. A register write is taken on any cycle in which `wr_en` is high. Neither can be refused.

Top module: `pll_lock_ctrl`

## Requirements
- R1: `mode` uses the encoding 2'b00 = in-lock, 2'b01 = inner aid, 2'b10 = outer aid, and never shows 2'b11. On reset:
  - `mode` is the outer aid.
  - `preset_value` is the nominal word 2^(FW-1) (FW = 2·BW), and `preset_load` is high in the first cycle after reset.
  - `flag_win` and `flag_lock` are low.
- R2: In the outer aid, an accepted check moves to the inner aid in the next cycle if |freq_word − nominal| ≤ nominal/10 (integer division; 3276 at the default width). Otherwise the mode stays outer. Each accepted check stores this window result in `flag_win`.
- R3: In the inner aid, LOCK_N consecutive accepted checks with `lock_det` = 1 move the mode to in-lock. A check with `lock_det` = 0 restarts the run.
- R4: In the inner aid, LOSS_M consecutive accepted checks whose frequency is outside the window move the mode back to the outer aid. An in-window check restarts that count.
- R5: In in-lock, LOSS_M consecutive accepted checks with `lock_det` = 0 move the mode back to the inner aid. A check with `lock_det` = 1 restarts that count. `flag_lock` is high exactly while the mode is in-lock.
- R6: Register 0 bits [1:0] select the operating control:
  - 0 is automatic.
  - 1 forces in-lock, 2 forces the inner aid, and 3 forces the outer aid.
  - A forced mode appears on `mode` two cycles after the write and stays there whatever checks arrive.
  - It clears the run counters, and automatic operation resumes from it.
- R7: A write to register 1 stores the high preset byte. A write to register 2 stores the low preset byte and triggers a preset. In the next cycle `preset_load` is high and `preset_value` = {high, low}. In the cycle after that `preset_hold` is high and `preset_load` is low. After that both are low.
- R8: A check arriving in a cycle where `preset_load` or `preset_hold` is high is discarded. It changes neither the mode, the counters nor `flag_win`.
- R9: `rd_data` is combinational from `rd_addr`:
  - Address 0 returns the control field.
  - Address 1 returns the status {zeros, mode[1:0], flag_lock, flag_win} (flag_win at bit 0).
  - Address 2 returns the top BW bits of `freq_word`.
  - Address 3 returns the high preset byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freq_word | input | 2*BW | Current loop integrator frequency word |
| chk_valid | input | 1 | Lock-detector check strobe |
| lock_det | input | 1 | Lock-detector result for this check |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Host write address |
| wr_data | input | BW | Host write data |
| rd_addr | input | 2 | Host read address |
| rd_data | output | BW | Host read data |
| mode | output | 2 | Selected loop mode |
| flag_win | output | 1 | Last accepted check was inside the inner window |
| flag_lock | output | 1 | Loop is in the in-lock mode |
| preset_load | output | 1 | Load `preset_value` into the integrator |
| preset_hold | output | 1 | Freeze integrator updates for this cycle |
| preset_value | output | 2*BW | Frequency word to load |

## Verification
A lock-detector check and a preset can fall in the same cycle. The bench provokes this by placing in-window checks exactly on the load cycle and on the hold cycle that follow a low-byte write, with the loop sitting in the outer aid. The mode must stay outer through both cycles, and it must move to the inner aid only on the first check after the hold. The window boundary is swept on both sides of nominal, and the climb and fall-back paths are driven with run lengths just below and at their thresholds.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic [1:0] {
    M_LOCK  = 2'b00,
    M_INNER = 2'b01,
    M_OUTER = 2'b10
  } mode_t;

  // control field code to forced mode (code 0 means automatic)
  function automatic mode_t ctrl_to_mode(input logic [1:0] code);
    case (code)
      2'd1:    return M_LOCK;
      2'd2:    return M_INNER;
      default: return M_OUTER;
    endcase
  endfunction
endpackage

// File: rtl/lc_window.sv
module lc_window #(
  parameter int FW = 16
) (
  input  logic [FW-1:0] freq,
  output logic          in_win
);
  localparam logic [FW-1:0] NOM = FW'(1) << (FW - 1);
  localparam logic [FW-1:0] TOL = NOM / FW'(10);

  logic [FW-1:0] diff;

  always_comb begin
    if (freq >= NOM) diff = freq - NOM;
    else             diff = NOM - freq;
    in_win = (diff <= TOL);
  end
endmodule

// File: rtl/lc_seq.sv
module lc_seq
  import pll_lock_pkg::*;
#(
  parameter int LOCK_N = 4,
  parameter int LOSS_M = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chk_valid,
  input  logic       lock_det,
  input  logic       in_win,
  input  logic       blank,
  input  logic [1:0] ctrl,
  output mode_t      mode,
  output logic       win_q
);
  localparam int LW = $clog2(LOCK_N + 1);
  localparam int MW = $clog2(LOSS_M + 1);
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_N - 1);
  localparam logic [MW-1:0] LOSS_LAST = MW'(LOSS_M - 1);

  mode_t         state;
  logic [LW-1:0] run_cnt;
  logic [MW-1:0] loss_cnt;
  logic          take;

  assign take = chk_valid && !blank;
  assign mode = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= M_OUTER;
      run_cnt  <= '0;
      loss_cnt <= '0;
      win_q    <= 1'b0;
    end else if (ctrl != 2'd0) begin
      state    <= ctrl_to_mode(ctrl);
      run_cnt  <= '0;
      loss_cnt <= '0;
      if (take) win_q <= in_win;
    end else if (take) begin
      win_q <= in_win;
      case (state)
        M_OUTER: begin
          if (in_win) begin
            state    <= M_INNER;
            run_cnt  <= '0;
            loss_cnt <= '0;
          end
        end
        M_INNER: begin
          if (!in_win) begin
            if (loss_cnt == LOSS_LAST) begin
              state    <= M_OUTER;
              loss_cnt <= '0;
              run_cnt  <= '0;
            end else begin
              loss_cnt <= loss_cnt + 1'b1;
            end
          end else begin
            loss_cnt <= '0;
          end
          if (in_win || loss_cnt != LOSS_LAST) begin
            if (lock_det) begin
              if (run_cnt == LOCK_LAST) begin
                state    <= M_LOCK;
                run_cnt  <= '0;
                loss_cnt <= '0;
              end else begin
                run_cnt <= run_cnt + 1'b1;
              end
            end else begin
              run_cnt <= '0;
            end
          end
        end
        default: begin
          if (!lock_det) begin
            if (loss_cnt == LOSS_LAST) begin
              state    <= M_INNER;
              loss_cnt <= '0;
              run_cnt  <= '0;
            end else begin
              loss_cnt <= loss_cnt + 1'b1;
            end
          end else begin
            loss_cnt <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lc_regs.sv
module lc_regs #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  output logic [1:0]    ctrl,
  output logic [BW-1:0] pre_hi,
  output logic [BW-1:0] pre_lo,
  output logic          load,
  output logic          hold
);
  localparam logic [BW-1:0] HI_NOM = BW'(1) << (BW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= 2'd0;
      pre_hi <= HI_NOM;
      pre_lo <= '0;
      load   <= 1'b1;
      hold   <= 1'b0;
    end else begin
      hold <= load;
      load <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: ctrl   <= wr_data[1:0];
          2'd1: pre_hi <= wr_data;
          2'd2: begin
            pre_lo <= wr_data;
            load   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_lock_pkg::*;
#(
  parameter int BW     = 8,
  parameter int LOCK_N = 4,
  parameter int LOSS_M = 3,
  localparam int FW    = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] freq_word,
  input  logic          chk_valid,
  input  logic          lock_det,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [BW-1:0] rd_data,
  output logic [1:0]    mode,
  output logic          flag_win,
  output logic          flag_lock,
  output logic          preset_load,
  output logic          preset_hold,
  output logic [FW-1:0] preset_value
);
  logic [1:0]    ctrl_q;
  logic [BW-1:0] pre_hi, pre_lo;
  logic          in_win, blank;
  mode_t         mode_s;

  lc_window #(.FW(FW)) u_win (
    .freq   (freq_word),
    .in_win (in_win)
  );

  lc_regs #(.BW(BW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl    (ctrl_q),
    .pre_hi  (pre_hi),
    .pre_lo  (pre_lo),
    .load    (preset_load),
    .hold    (preset_hold)
  );

  assign blank = preset_load | preset_hold;

  lc_seq #(.LOCK_N(LOCK_N), .LOSS_M(LOSS_M)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .lock_det  (lock_det),
    .in_win    (in_win),
    .blank     (blank),
    .ctrl      (ctrl_q),
    .mode      (mode_s),
    .win_q     (flag_win)
  );

  assign mode         = mode_s;
  assign flag_lock    = (mode_s == M_LOCK);
  assign preset_value = {pre_hi, pre_lo};

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {{(BW-2){1'b0}}, ctrl_q};
      2'd1:    rd_data = {{(BW-4){1'b0}}, mode_s, flag_lock, flag_win};
      2'd2:    rd_data = freq_word[FW-1 -: BW];
      default: rd_data = pre_hi;
    endcase
  end
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       chk_valid,
  input logic       in_win,
  input logic [1:0] ctrl_q,
  input logic       preset_load,
  input logic       preset_hold
);
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  p_outer_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && ctrl_q == 2'd0 && chk_valid && in_win &&
     !preset_load && !preset_hold) |=> mode == 2'b01);

  p_lock_falls_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && ctrl_q == 2'd0) |=> mode != 2'b10);

  p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 2'd3) |=> mode == 2'b10);

  p_load_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> preset_hold);

  p_blank_keeps_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((preset_load || preset_hold) && ctrl_q == 2'd0) |=> $stable(mode));
endmodule

bind pll_lock_ctrl lc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .chk_valid   (chk_valid),
  .in_win      (in_win),
  .ctrl_q      (ctrl_q),
  .preset_load (preset_load),
  .preset_hold (preset_hold)
);

// File: tb/tb_pll_lock_ctrl.sv
`timescale 1ns/1ps
module tb_pll_lock_ctrl;
  localparam int BW = 8, FW = 16, LN = 3, LM = 2;
  localparam int NOM = 32768, TOL = 3276;

  logic clk = 0, rst_n = 0;
  logic [FW-1:0] freq_word = NOM[FW-1:0];
  logic chk_valid = 0, lock_det = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [BW-1:0] wr_data = 0, rd_data;
  logic [1:0] mode;
  logic flag_win, flag_lock, preset_load, preset_hold;
  logic [FW-1:0] preset_value;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pll_lock_ctrl #(.BW(BW), .LOCK_N(LN), .LOSS_M(LM)) dut (.*);

  task automatic expect_eq(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk(input logic ld);
    chk_valid = 1; lock_det = ld;
    @(negedge clk);
    chk_valid = 0;
  endtask

  task automatic set_mode(input logic [1:0] code);
    wr(0, {6'b0, code});
    wr(0, 8'd0);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_eq("R1 mode", mode, 2);
    expect_eq("R1 load", preset_load, 1);
    expect_eq("R1 value", preset_value, NOM);
    expect_eq("R1 flags", {flag_win, flag_lock}, 0);
    idle();
    expect_eq("R7 reset hold", {preset_load, preset_hold}, 1);
    idle();

    // R2 window sweep on both sides of nominal
    for (int s = -1; s <= 1; s += 2)
      for (int k = -2; k <= 2; k++) begin
        int off = TOL + k;
        set_mode(2'd3);
        freq_word = FW'(NOM + s * off);
        chk(0);
        expect_eq($sformatf("R2 off=%0d", s * off), mode, (off <= TOL) ? 1 : 2);
        expect_eq("R2 flag_win", flag_win, (off <= TOL) ? 1 : 0);
      end

    // R3 run lengths up to LN
    freq_word = NOM[FW-1:0];
    for (int c = 1; c <= LN; c++) begin
      set_mode(2'd2);
      for (int i = 0; i < c; i++) chk(1);
      expect_eq($sformatf("R3 run=%0d", c), mode, (c == LN) ? 0 : 1);
    end
    set_mode(2'd2);
    chk(1); chk(1); chk(0); chk(1); chk(1);
    expect_eq("R3 broken run", mode, 1);
    chk(1);
    expect_eq("R3 run after break", mode, 0);
    expect_eq("R5 flag_lock", flag_lock, 1);

    // R4 inner losing window
    set_mode(2'd2);
    freq_word = FW'(NOM + TOL + 1);
    chk(0);
    expect_eq("R4 one miss", mode, 1);
    freq_word = NOM[FW-1:0]; chk(0);
    freq_word = FW'(NOM - TOL - 1); chk(0);
    expect_eq("R4 interrupted", mode, 1);
    chk(0);
    expect_eq("R4 fall to outer", mode, 2);

    // R5 in-lock losing lock
    freq_word = NOM[FW-1:0];
    set_mode(2'd1);
    expect_eq("R6 force lock", mode, 0);
    chk(0); chk(1); chk(0);
    expect_eq("R5 interrupted", mode, 0);
    chk(0);
    expect_eq("R5 fall to inner", mode, 1);
    expect_eq("R5 flag_lock low", flag_lock, 0);

    // R6 held force ignores checks
    wr(0, 8'd3);
    idle();
    expect_eq("R6 forced outer", mode, 2);
    chk(1);
    expect_eq("R6 force holds", mode, 2);
    rd_addr = 0; #1;
    expect_eq("R9 ctrl read", rd_data, 3);
    wr(0, 8'd0);
    idle();

    // R7 preset path
    wr(1, 8'h12);
    wr_en = 1; wr_addr = 2; wr_data = 8'h34;
    @(negedge clk); wr_en = 0;
    expect_eq("R7 load", {preset_load, preset_hold}, 2);
    expect_eq("R7 value", preset_value, 16'h1234);
    idle();
    expect_eq("R7 hold", {preset_load, preset_hold}, 1);
    idle();
    expect_eq("R7 done", {preset_load, preset_hold}, 0);

    // R8 checks colliding with load and hold, mode outer
    set_mode(2'd3);
    freq_word = NOM[FW-1:0];
    chk(0);
    set_mode(2'd3);
    freq_word = FW'(NOM + TOL + 5);
    chk(0);
    expect_eq("R8 setup flag", flag_win, 0);
    freq_word = NOM[FW-1:0];
    wr(2, 8'h00);
    chk(0);
    expect_eq("R8 during load", mode, 2);
    chk(0);
    expect_eq("R8 during hold", mode, 2);
    expect_eq("R8 flag untouched", flag_win, 0);
    chk(0);
    expect_eq("R8 after hold", mode, 1);

    // R9 readback
    freq_word = 16'hA5C3;
    rd_addr = 1; #1;
    expect_eq("R9 status", rd_data, {4'b0, 2'b01, 1'b0, 1'b1});
    rd_addr = 2; #1;
    expect_eq("R9 freq top", rd_data, 8'hA5);
    rd_addr = 3; #1;
    expect_eq("R9 preset hi", rd_data, 8'h12);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule